// File: doc/BRIEF.md
# Priority Transmit Buffer Scheduler

This block keeps the state of a small set of transmit message slots for a CAN-style controller and decides which slot goes to the bus next. Software moves slots between states by writing a command that carries a slot select bitmap together with abort, set-ready and set-empty bits. Each slot has a 3-bit priority. The block hands the index of the chosen slot to an external transmit engine and waits for that engine to report success or failure.

When a frame completes, the slot's state is updated and a frame counter advances. One-cycle interrupt events are raised, and the next ready slot is selected. Status outputs report whether any slot is free and whether a transmission is in flight. A second counter tallies received frames. Each counter has its own clear input. The bit-level transmitter and the message storage sit outside the block.

Top module: `tx_sched`

## Requirements
- R1: After reset every slot is empty, so `status_o` reads 32'h0000_1111. Priorities, both counters and both interrupt outputs read 0; `idle_o` and `txnf_o` are 1 and `tx_req_o` is 0. Slot i's state is the nibble at bits [4i+3:4i] of `status_o`, encoded as empty=1, ready=2, sent-ok=4, error=6, aborted=7.
- R2: Abort turns a selected slot into aborted only when it is ready. It leaves a slot in any other state unchanged.
- R3: Set-ready turns a selected slot that is empty, sent-ok, error or aborted into ready.
- R4: Set-empty turns a selected slot that is sent-ok, error or aborted into empty. It has no effect on a ready slot or an empty slot.
- R5: When one command carries several command bits, they are applied in a fixed sequence: abort first, then set-ready, then set-empty. Each step acts on the state left by the step before it.
- R6: While `enable_i` is 0, slot commands have no effect and no new transmission starts.
- R7: The scheduler picks the ready slot with the highest priority. Equal priorities go to the lowest index, and a slot with priority 0 is never picked. The pick becomes `tx_idx_o` one cycle after the slot is ready.
- R8: A `tx_done_i` during a transmission makes the slot sent-ok and increments `tx_cnt_o`. It also raises `irq_txdone_o` and `irq_bufchg_o` for exactly one cycle in the following cycle. Selection then resumes.
- R9: A `tx_err_i` without `tx_done_i` during a transmission makes the slot error. It leaves `tx_cnt_o` unchanged and pulses only `irq_bufchg_o`.
- R10: `txnf_o` is 1 exactly when at least one slot is empty.
- R11: While a transmission is in flight, `tx_req_o` and `tx_busy_o` are 1 and `idle_o` is 0.
- R12: `clr_tx_cnt_i` and `clr_rx_cnt_i` zero their counter on the next edge, whatever the value of `enable_i`, and take precedence over a same-cycle increment. `rx_frame_i` increments `rx_cnt_o`.
- R13: A priority write stores bits [4i+2:4i] of `prio_wdata_i` as slot i's priority. All other bits of `prio_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable |
| cmd_valid_i | input | 1 | Slot command strobe |
| cmd_sel_i | input | 4 | Slot select bitmap |
| cmd_abort_i | input | 1 | Abort command bit |
| cmd_ready_i | input | 1 | Set-ready command bit |
| cmd_empty_i | input | 1 | Set-empty command bit |
| clr_tx_cnt_i | input | 1 | Clear transmitted-frame counter |
| clr_rx_cnt_i | input | 1 | Clear received-frame counter |
| rx_frame_i | input | 1 | One received frame |
| prio_we_i | input | 1 | Priority word write strobe |
| prio_wdata_i | input | 32 | Priority word data |
| tx_done_i | input | 1 | Engine reports successful send |
| tx_err_i | input | 1 | Engine reports failed send |
| tx_req_o | output | 1 | Transmission requested |
| tx_idx_o | output | 2 | Index of slot in flight |
| status_o | output | 32 | Packed slot state nibbles |
| prio_o | output | 32 | Packed priorities |
| txnf_o | output | 1 | Some slot is empty |
| tx_busy_o | output | 1 | Transmission in flight |
| idle_o | output | 1 | No transmission in flight |
| irq_txdone_o | output | 1 | Frame sent event pulse |
| irq_bufchg_o | output | 1 | Slot state changed by engine event pulse |
| tx_cnt_o | output | 16 | Transmitted-frame counter |
| rx_cnt_o | output | 16 | Received-frame counter |

## Verification
A slot nibble that took a wrong transition shows on `status_o` at the sample right after the command edge. That includes a command step applied out of sequence. A wrong pick shows one edge later as the wrong `tx_idx_o`; a lost tie-break or a priority-0 slot being sent shows the same way. A completion handled wrongly shows on the edge that accepts it, as a wrong nibble, counter value or interrupt pair. A selection that wrongly stalls or runs while disabled shows within one cycle on `tx_busy_o` and `idle_o`.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic [3:0] {
    ST_EMPTY   = 4'd1,
    ST_READY   = 4'd2,
    ST_TX_OK   = 4'd4,
    ST_ERROR   = 4'd6,
    ST_ABORTED = 4'd7
  } buf_state_e;

  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_BUSY = 1'b1
  } sched_e;
endpackage

// File: rtl/tx_buf_fsm.sv
module tx_buf_fsm
  import tx_sched_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_hit_i,
  input  logic       cmd_abort_i,
  input  logic       cmd_ready_i,
  input  logic       cmd_empty_i,
  input  logic       done_ok_i,
  input  logic       done_err_i,
  output logic [3:0] state_o
);
  buf_state_e state_q, state_d;

  // command steps are applied in sequence, each on the previous result
  always_comb begin
    state_d = state_q;
    if (cmd_hit_i) begin
      if (cmd_abort_i && state_d == ST_READY) state_d = ST_ABORTED;
      if (cmd_ready_i && state_d != ST_READY) state_d = ST_READY;
      if (cmd_empty_i && (state_d == ST_TX_OK || state_d == ST_ERROR ||
                          state_d == ST_ABORTED)) state_d = ST_EMPTY;
    end
    if (done_ok_i)       state_d = ST_TX_OK;
    else if (done_err_i) state_d = ST_ERROR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_legal_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_EMPTY, ST_READY, ST_TX_OK, ST_ERROR, ST_ABORTED});

  assert_done_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ok_i |=> state_q == ST_TX_OK);

  assert_ready_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit_i && cmd_empty_i && !cmd_abort_i && state_q == ST_READY &&
     !done_ok_i && !done_err_i) |=> state_q == ST_READY);

  assert_abort_only_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit_i && cmd_abort_i && !cmd_ready_i && !cmd_empty_i &&
     state_q != ST_READY && !done_ok_i && !done_err_i) |=> $stable(state_q));
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick
  import tx_sched_pkg::*;
#(
  parameter int N_BUF  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N_BUF > 1) ? $clog2(N_BUF) : 1
) (
  input  logic [N_BUF-1:0][3:0]        state_i,
  input  logic [N_BUF-1:0][PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best;

  // strictly-greater scan from 0: ties keep lowest index, priority 0 never wins
  always_comb begin
    best    = '0;
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < N_BUF; i++) begin
      if (state_i[i] == ST_READY && prio_i[i] > best) begin
        best    = prio_i[i];
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_frame_ctr.sv
module tx_frame_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  assert_count_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/tx_sched.sv
module tx_sched
  import tx_sched_pkg::*;
#(
  parameter int N_BUF   = 4,
  parameter int PRIO_W  = 3,
  parameter int FIELD_W = 4,
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (N_BUF > 1) ? $clog2(N_BUF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              cmd_valid_i,
  input  logic [N_BUF-1:0]  cmd_sel_i,
  input  logic              cmd_abort_i,
  input  logic              cmd_ready_i,
  input  logic              cmd_empty_i,
  input  logic              clr_tx_cnt_i,
  input  logic              clr_rx_cnt_i,
  input  logic              rx_frame_i,
  input  logic              prio_we_i,
  input  logic [WORD_W-1:0] prio_wdata_i,
  input  logic              tx_done_i,
  input  logic              tx_err_i,
  output logic              tx_req_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] prio_o,
  output logic              txnf_o,
  output logic              tx_busy_o,
  output logic              idle_o,
  output logic              irq_txdone_o,
  output logic              irq_bufchg_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic [CNT_W-1:0]  rx_cnt_o
);
  logic [N_BUF-1:0][3:0]        state_w;
  logic [N_BUF-1:0][PRIO_W-1:0] prio_q;
  logic [N_BUF-1:0]             empty_w;
  logic                         pick_found;
  logic [IDX_W-1:0]             pick_idx;
  sched_e                       sch_q;
  logic [IDX_W-1:0]             busy_idx_q;
  logic                         cmd_go, done_ok, done_err;
  logic                         unused_prio_bits;

  assign unused_prio_bits = ^prio_wdata_i;
  assign cmd_go   = cmd_valid_i & enable_i;
  assign done_ok  = (sch_q == SCH_BUSY) & tx_done_i;
  assign done_err = (sch_q == SCH_BUSY) & tx_err_i & ~tx_done_i;

  for (genvar i = 0; i < N_BUF; i++) begin : g_buf
    tx_buf_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_hit_i  (cmd_go & cmd_sel_i[i]),
      .cmd_abort_i(cmd_abort_i),
      .cmd_ready_i(cmd_ready_i),
      .cmd_empty_i(cmd_empty_i),
      .done_ok_i  (done_ok  & (busy_idx_q == IDX_W'(i))),
      .done_err_i (done_err & (busy_idx_q == IDX_W'(i))),
      .state_o    (state_w[i])
    );
    assign empty_w[i] = (state_w[i] == ST_EMPTY);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        prio_q[i] <= '0;
      else if (prio_we_i) prio_q[i] <= prio_wdata_i[i*FIELD_W +: PRIO_W];
    end
  end

  always_comb begin
    status_o = '0;
    prio_o   = '0;
    for (int i = 0; i < N_BUF; i++) begin
      status_o[i*FIELD_W +: FIELD_W] = FIELD_W'(state_w[i]);
      prio_o[i*FIELD_W +: PRIO_W]    = prio_q[i];
    end
  end

  tx_prio_pick #(.N_BUF(N_BUF), .PRIO_W(PRIO_W)) u_pick (
    .state_i(state_w),
    .prio_i (prio_q),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sch_q      <= SCH_IDLE;
      busy_idx_q <= '0;
    end else if (sch_q == SCH_IDLE) begin
      if (enable_i && pick_found) begin
        sch_q      <= SCH_BUSY;
        busy_idx_q <= pick_idx;
      end
    end else if (tx_done_i || tx_err_i) begin
      sch_q <= SCH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_txdone_o <= 1'b0;
      irq_bufchg_o <= 1'b0;
    end else begin
      irq_txdone_o <= done_ok;
      irq_bufchg_o <= done_ok | done_err;
    end
  end

  tx_frame_ctr #(.CNT_W(CNT_W)) u_tx_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_tx_cnt_i),
    .inc_i (done_ok),
    .cnt_o (tx_cnt_o)
  );

  tx_frame_ctr #(.CNT_W(CNT_W)) u_rx_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_rx_cnt_i),
    .inc_i (rx_frame_i),
    .cnt_o (rx_cnt_o)
  );

  assign tx_req_o  = (sch_q == SCH_BUSY);
  assign tx_busy_o = tx_req_o;
  assign idle_o    = ~tx_req_o;
  assign tx_idx_o  = busy_idx_q;
  assign txnf_o    = |empty_w;

  assert_no_start_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && sch_q == SCH_IDLE) |=> sch_q == SCH_IDLE);

  assert_cmd_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !tx_done_i && !tx_err_i) |=> $stable(status_o));

  assert_pick_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_found |-> (state_w[pick_idx] == ST_READY && prio_q[pick_idx] != '0));

  assert_irq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_txdone_o |=> !irq_txdone_o);

  assert_err_no_txdone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_err |=> (irq_bufchg_o && !irq_txdone_o));
endmodule

// File: tb/sim_tx_sched.sv
module sim_tx_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_sel_i = '0;
  logic        cmd_abort_i = 1'b0, cmd_ready_i = 1'b0, cmd_empty_i = 1'b0;
  logic        clr_tx_cnt_i = 1'b0, clr_rx_cnt_i = 1'b0, rx_frame_i = 1'b0;
  logic        prio_we_i = 1'b0;
  logic [31:0] prio_wdata_i = '0;
  logic        tx_done_i = 1'b0, tx_err_i = 1'b0;
  logic        tx_req_o;
  logic [1:0]  tx_idx_o;
  logic [31:0] status_o, prio_o;
  logic        txnf_o, tx_busy_o, idle_o, irq_txdone_o, irq_bufchg_o;
  logic [15:0] tx_cnt_o, rx_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  tx_sched u0 (.*);

  // {sel[3:0], abort, ready, empty, expected status[15:0]}
  localparam logic [22:0] VEC [10] = '{
    {4'b1111, 3'b010, 16'h2222},
    {4'b0101, 3'b100, 16'h2727},
    {4'b1111, 3'b001, 16'h2121},
    {4'b0011, 3'b110, 16'h2122},
    {4'b0010, 3'b101, 16'h2112},
    {4'b1000, 3'b111, 16'h2112},
    {4'b1000, 3'b101, 16'h1112},
    {4'b0100, 3'b001, 16'h1112},
    {4'b0000, 3'b010, 16'h1112},
    {4'b1111, 3'b100, 16'h1117}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] sel, input logic a, input logic r, input logic e);
    cmd_valid_i = 1'b1; cmd_sel_i = sel;
    cmd_abort_i = a; cmd_ready_i = r; cmd_empty_i = e;
    @(posedge clk_i); @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_sel_i = '0;
    cmd_abort_i = 1'b0; cmd_ready_i = 1'b0; cmd_empty_i = 1'b0;
  endtask

  task automatic wprio(input logic [31:0] d);
    prio_we_i = 1'b1; prio_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    prio_we_i = 1'b0;
  endtask

  task automatic finish_tx(input logic ok);
    tx_done_i = ok; tx_err_i = ~ok;
    @(posedge clk_i); @(negedge clk_i);
    tx_done_i = 1'b0; tx_err_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 status", status_o, 32'h0000_1111);
    chk("R1 prio", prio_o, 32'h0);
    chk("R1 flags", {27'd0, txnf_o, idle_o, tx_busy_o, irq_txdone_o, irq_bufchg_o}, 32'b11000);
    chk("R1 counters", {tx_cnt_o, rx_cnt_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 commands ignored while disabled
    cmd(4'b1111, 1'b0, 1'b1, 1'b0);
    chk("R6 cmd ignored", status_o, 32'h0000_1111);

    // R2 R3 R4 R5 R10 vector walk, all priorities 0 so nothing transmits
    enable_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cmd(VEC[k][22:19], VEC[k][18], VEC[k][17], VEC[k][16]);
      chk($sformatf("R5 vector %0d status", k), status_o, {16'h0, VEC[k][15:0]});
      chk($sformatf("R10 vector %0d txnf", k), {31'd0, txnf_o},
          {31'd0, (VEC[k][3:0] == 4'h1) | (VEC[k][7:4] == 4'h1) |
                  (VEC[k][11:8] == 4'h1) | (VEC[k][15:12] == 4'h1)});
    end
    chk("R7 prio0 never sent", {31'd0, tx_busy_o}, 32'd0);

    // R13 priority field layout
    wprio(32'hFFFF_FFFF);
    chk("R13 prio readback", prio_o, 32'h0000_7777);
    wprio(32'h0000_5530);
    chk("R13 prio fields", prio_o, 32'h0000_5530);

    cmd(4'b1111, 1'b0, 1'b0, 1'b1);
    chk("R4 abort to empty", status_o, 32'h0000_1111);
    cmd(4'b1111, 1'b0, 1'b1, 1'b0);
    chk("R3 all ready", status_o, 32'h0000_2222);
    chk("R11 not yet busy", {31'd0, idle_o}, 32'd1);
    @(negedge clk_i);
    chk("R7 tie lowest index", {30'd0, tx_idx_o}, 32'd2);
    chk("R11 busy flags", {29'd0, tx_req_o, tx_busy_o, idle_o}, 32'b110);
    finish_tx(1'b1);
    chk("R8 slot sent ok", status_o, 32'h0000_2422);
    chk("R8 count", {16'd0, tx_cnt_o}, 32'd1);
    chk("R8 irqs", {30'd0, irq_txdone_o, irq_bufchg_o}, 32'b11);
    @(negedge clk_i);
    chk("R8 irq single pulse", {30'd0, irq_txdone_o, irq_bufchg_o}, 32'b00);
    chk("R7 second pick", {30'd0, tx_idx_o}, 32'd3);
    finish_tx(1'b1);
    @(negedge clk_i);
    chk("R7 third pick", {30'd0, tx_idx_o}, 32'd1);
    finish_tx(1'b1);
    chk("R8 after three", status_o, 32'h0000_4442);
    chk("R8 count three", {16'd0, tx_cnt_o}, 32'd3);
    chk("R10 none empty", {31'd0, txnf_o}, 32'd0);
    @(negedge clk_i);
    chk("R7 prio0 stays ready", {30'd0, tx_busy_o, idle_o}, 32'b01);

    // R9 error completion
    wprio(32'h0000_0001);
    @(negedge clk_i);
    chk("R9 busy on slot0", {29'd0, tx_busy_o, tx_idx_o}, 32'b100);
    finish_tx(1'b0);
    chk("R9 error state", status_o, 32'h0000_4446);
    chk("R9 count unchanged", {16'd0, tx_cnt_o}, 32'd3);
    chk("R9 irqs", {30'd0, irq_txdone_o, irq_bufchg_o}, 32'b01);

    // R6 no start while disabled
    wprio(32'h0);
    cmd(4'b0001, 1'b0, 1'b1, 1'b0);
    chk("R3 error to ready", status_o, 32'h0000_4442);
    enable_i = 1'b0;
    wprio(32'h0000_0001);
    repeat (3) @(negedge clk_i);
    chk("R6 no start", {30'd0, tx_busy_o, idle_o}, 32'b01);
    enable_i = 1'b1;
    @(negedge clk_i);
    chk("R6 start after enable", {30'd0, tx_busy_o, idle_o}, 32'b10);
    finish_tx(1'b1);
    chk("R8 count four", {16'd0, tx_cnt_o}, 32'd4);

    // R10 R4 sent-ok to empty
    cmd(4'b1000, 1'b0, 1'b0, 1'b1);
    chk("R4 ok to empty", status_o, 32'h0000_1444);
    chk("R10 txnf back", {31'd0, txnf_o}, 32'd1);

    // R12 counters, clears work while disabled
    enable_i = 1'b0;
    rx_frame_i = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rx_frame_i = 1'b0;
    chk("R12 rx count", {16'd0, rx_cnt_o}, 32'd2);
    clr_tx_cnt_i = 1'b1; clr_rx_cnt_i = 1'b1; rx_frame_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    clr_tx_cnt_i = 1'b0; clr_rx_cnt_i = 1'b0; rx_frame_i = 1'b0;
    chk("R12 clears", {tx_cnt_o, rx_cnt_o}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule